// File: doc/BRIEF.md
# Absolute-Indexed Load/Store Bus Sequencer

This block sequences the memory bus cycles of an 8-bit processor's absolute-indexed loads and stores, one access per clock. When idle, it accepts an operation class, a program-counter address, an index value and a store value. It then fetches the opcode byte and the two operand bytes, and forms an effective address from the base plus the index. The access that follows reproduces the processor's cycle timing exactly.

A load finishes in four cycles when the indexed address stays inside the base page. When the low-byte addition carries into the next page, the fourth cycle reads at the uncorrected address and that data is thrown away. A fifth cycle then reads again at the corrected address. A regular store always spends cycle four on a dummy read and writes in cycle five.

A third class models the defective store that lacks the high-byte fixup. It writes the store value ANDed with the base high byte plus one. When a page is crossed, that same ANDed byte also replaces the high half of the write address. The byte a load reads is held in a result buffer, and the buffer is visible from the clock after the done pulse.

Top module: `idx_abs_seq`

## Requirements
- R1: While `rst_n` is low and after it is released, `busy`, `done` and `we` are 0 and `ld_data` is 0 until the first load completes.
- R2: After `start` is sampled high in idle, the next three cycles are reads (`we`=0) at `pc`, `pc`+1 and `pc`+2, all taken modulo 2^16. The second cycle's read byte is the base low byte and the third cycle's read byte is the base high byte.
- R3: With `op`=2'b00 (a load; 2'b11 behaves the same), when low byte + index is below 256, cycle 4 reads at {high, low+index} and is the last cycle.
- R4: For a load whose low byte + index is 256 or more, cycle 4 reads at {high, (low+index) mod 256}. Cycle 5 then reads at {high+1 mod 256, (low+index) mod 256} and is the last cycle.
- R5: After a load, `ld_data` equals the byte read in its last cycle, from the clock after `done` onward. `ld_data` is left unchanged by stores.
- R6: With `op`=2'b01 (store), cycle 4 is a read at {high, (low+index) mod 256}. Cycle 5 writes `wval` at {high + carry, (low+index) mod 256}, where carry is 1 on a page cross. A store always takes five cycles.
- R7: With `op`=2'b10 (defective store) and no page cross, cycle 4 is a read and cycle 5 writes `wval` AND (high+1 mod 256) at {high, low+index}.
- R8: For the defective store with a page cross, cycle 5 writes at {`wval` AND (high+1), (low+index) mod 256}, with that same AND value as the data.
- R9: `done` is high for exactly one clock, on the last bus cycle. `busy` is high from cycle 1 through the last cycle. `we` is high only in a store's last cycle.
- R10: `start`, `op`, `pc`, `idx` and `wval` are ignored while `busy` is high, so the sequence in flight is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (sampled only when idle) |
| op | input | 2 | 00/11 load, 01 store, 10 defective store |
| pc | input | 2*DW | Address of the opcode byte |
| idx | input | DW | Index register value |
| wval | input | DW | Value to store |
| rd_data | input | DW | Read data returned by memory in the same cycle |
| addr | output | 2*DW | Bus address |
| we | output | 1 | Write strobe |
| wdata | output | DW | Write data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Final bus cycle of the operation |
| ld_data | output | DW | Load result buffer |

## Verification
The bench builds the block with its default data width of 8, so addresses are 16 bits and the page is 256 bytes. At that width the bench can drive every page boundary of interest: a low byte of 0xFF with index 1, a base high byte of 0xFF whose increment wraps to zero, and an opcode fetch at 0xFFFE that wraps the program counter. Its reference model predicts the full address, strobe, data and done pattern of every cycle. It also covers defective-store masks that clear, keep and redirect the address high byte.

// File: rtl/idx_abs_seq.sv
module idx_abs_seq #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    op,
  input  logic [2*DW-1:0] pc,
  input  logic [DW-1:0] idx,
  input  logic [DW-1:0] wval,
  input  logic [DW-1:0] rd_data,
  output logic [2*DW-1:0] addr,
  output logic          we,
  output logic [DW-1:0] wdata,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] ld_data
);
  localparam int AW = 2 * DW;

  typedef enum logic [2:0] {S_IDLE, S_C1, S_C2, S_C3, S_C4, S_C5} st_t;

  st_t            st;
  logic [1:0]     opr;
  logic [AW-1:0]  pcr;
  logic [DW-1:0]  idxr, wvr, lo, hi, sum, ldb;
  logic           cry;

  wire is_st   = (opr == 2'b01);
  wire is_bad  = (opr == 2'b10);
  wire is_ld   = !is_st && !is_bad;
  wire [DW-1:0] hi_inc = DW'(hi + 1'b1);
  wire [DW-1:0] mask   = wvr & hi_inc;

  assign busy = (st != S_IDLE);
  assign done = (st == S_C5) || (st == S_C4 && is_ld && !cry);
  assign we   = (st == S_C5) && !is_ld;
  assign wdata = is_bad ? mask : wvr;
  assign ld_data = ldb;

  always_comb begin
    case (st)
      S_C1:    addr = pcr;
      S_C2:    addr = AW'(pcr + 1'b1);
      S_C3:    addr = AW'(pcr + 2'd2);
      S_C4:    addr = {hi, sum};
      S_C5: begin
        if (is_ld)       addr = {hi_inc, sum};
        else if (is_st)  addr = {cry ? hi_inc : hi, sum};
        else             addr = {cry ? mask : hi, sum};
      end
      default: addr = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      opr  <= '0;
      pcr  <= '0;
      idxr <= '0;
      wvr  <= '0;
      lo   <= '0;
      hi   <= '0;
      sum  <= '0;
      cry  <= 1'b0;
      ldb  <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st   <= S_C1;
          opr  <= op;
          pcr  <= pc;
          idxr <= idx;
          wvr  <= wval;
        end
        S_C1: st <= S_C2;
        S_C2: begin
          lo <= rd_data;
          st <= S_C3;
        end
        S_C3: begin
          hi <= rd_data;
          {cry, sum} <= {1'b0, lo} + {1'b0, idxr};
          st <= S_C4;
        end
        S_C4: begin
          if (is_ld && !cry) begin
            ldb <= rd_data;
            st  <= S_IDLE;
          end else begin
            st <= S_C5;
          end
        end
        S_C5: begin
          if (is_ld) ldb <= rd_data;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module idx_abs_seq_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          we,
  input logic [DW-1:0] ld_data
);
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  p_done_busy_r9:  assert property (@(posedge clk) disable iff (!rst_n) done |-> busy);
  p_we_final_r9:   assert property (@(posedge clk) disable iff (!rst_n) we |-> done);
  p_no_cut_r10:    assert property (@(posedge clk) disable iff (!rst_n) (busy && !done) |=> busy);
  p_first_rd_r2:   assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> !we && !done);
  p_idle_r1:       assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !we && !done);
  p_ld_hold_r5:    assert property (@(posedge clk) disable iff (!rst_n) !$past(done) |-> $stable(ld_data));
endmodule

bind idx_abs_seq idx_abs_seq_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .we(we), .ld_data(ld_data)
);

// File: tb/tb_idx_abs_seq.sv
module tb_idx_abs_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = '0;
  logic [15:0] pc = '0;
  logic [7:0]  idx = '0, wval = '0, rd_data;
  logic [15:0] addr;
  logic        we, busy, done;
  logic [7:0]  wdata, ld_data;

  int checks = 0, fails = 0;
  int mem_ver = 0;
  logic [7:0] mem [int unsigned];
  logic [7:0] exp_ld = 8'h00;

  always #2 clk = ~clk;

  idx_abs_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .pc(pc), .idx(idx),
    .wval(wval), .rd_data(rd_data), .addr(addr), .we(we), .wdata(wdata),
    .busy(busy), .done(done), .ld_data(ld_data)
  );

  function automatic logic [7:0] rdmem(input logic [15:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  always @(addr, mem_ver) rd_data = rdmem(addr);

  always @(posedge clk) if (rst_n && we) begin
    mem[int'(addr)] = wdata;
    mem_ver++;
  end

  task automatic chk(input string tag, input bit ok, input string act, input string expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%s expected=%s", tag, act, expv);
    end
  endtask

  task automatic run(input logic [1:0] o, input logic [15:0] p, input logic [7:0] lo,
                     input logic [7:0] hi, input logic [7:0] ix, input logic [7:0] wv,
                     input bit glitch);
    logic [15:0] ea [5];
    bit          ew [5];
    logic [7:0]  ed [5];
    int n;
    logic [8:0] s9;
    logic [7:0] s, hi1, m;
    bit c, ld;
    ld  = (o == 2'b00) || (o == 2'b11);
    mem[int'(p)] = 8'hBD;
    mem[int'(16'(p + 1))] = lo;
    mem[int'(16'(p + 2))] = hi;
    mem_ver++;
    s9 = {1'b0, lo} + {1'b0, ix};
    s = s9[7:0]; c = s9[8]; hi1 = hi + 8'd1; m = wv & hi1;
    ea[0] = p; ea[1] = 16'(p + 1); ea[2] = 16'(p + 2);
    for (int i = 0; i < 5; i++) begin ew[i] = 0; ed[i] = 'x; end
    ea[3] = {hi, s};
    if (ld) begin
      n = c ? 5 : 4;
      ea[4] = {hi1, s};
      exp_ld = rdmem(ea[n-1]);
    end else if (o == 2'b01) begin
      n = 5; ea[4] = {c ? hi1 : hi, s}; ew[4] = 1; ed[4] = wv;
    end else begin
      n = 5; ea[4] = {c ? m : hi, s}; ew[4] = 1; ed[4] = m;
    end
    @(negedge clk);
    start = 1; op = o; pc = p; idx = ix; wval = wv;
    @(negedge clk);
    start = 0;
    for (int k = 0; k < n; k++) begin
      string tag;
      bit ok;
      if (k < 3) tag = "R2";
      else if (ld) tag = c ? "R4" : "R3";
      else if (o == 2'b01) tag = "R6";
      else tag = c ? "R8" : "R7";
      if (glitch) tag = {tag, "/R10"};
      ok = (addr === ea[k]) && (we === ew[k]) && (busy === 1'b1) &&
           (done === (k == n-1)) && (!ew[k] || wdata === ed[k]);
      if (!ok && done !== (k == n-1)) tag = {tag, "/R9"};
      chk(tag, ok,
          $sformatf("cyc%0d a=%h we=%b wd=%h d=%b", k+1, addr, we, wdata, done),
          $sformatf("cyc%0d a=%h we=%b wd=%h d=%b", k+1, ea[k], ew[k], ed[k], k == n-1));
      if (glitch && k == 1) begin start = 1; op = ~o; pc = 16'h1234; idx = 8'h77; wval = 8'h00; end
      if (k < n-1) @(negedge clk);
      if (glitch && k == 2) start = 0;
    end
    @(negedge clk);
    start = 0;
    chk("R9", busy === 1'b0 && done === 1'b0 && we === 1'b0,
        $sformatf("busy=%b done=%b we=%b", busy, done, we), "busy=0 done=0 we=0");
    chk("R5", ld_data === exp_ld, $sformatf("%h", ld_data), $sformatf("%h", exp_ld));
    if (!ld) chk(o == 2'b01 ? "R6" : "R7", mem[int'(ea[4])] === ed[4],
                 $sformatf("%h", mem[int'(ea[4])]), $sformatf("%h", ed[4]));
  endtask

  initial begin
    #200000;
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", busy === 0 && done === 0 && we === 0 && ld_data === 8'h00,
        $sformatf("b=%b d=%b w=%b ld=%h", busy, done, we, ld_data), "b=0 d=0 w=0 ld=00");
    rst_n = 1;
    @(negedge clk);
    chk("R1", busy === 0 && done === 0 && we === 0,
        $sformatf("b=%b d=%b w=%b", busy, done, we), "b=0 d=0 w=0");
    run(2'b00, 16'h0200, 8'h10, 8'h40, 8'h05, 8'h00, 0);
    run(2'b00, 16'h0300, 8'hF0, 8'h41, 8'h20, 8'h00, 0);
    run(2'b00, 16'h0310, 8'hFF, 8'h42, 8'h01, 8'h00, 0);
    run(2'b11, 16'h0320, 8'h33, 8'h43, 8'h00, 8'h00, 0);
    run(2'b00, 16'hFFFE, 8'h80, 8'hFF, 8'h90, 8'h00, 0);
    run(2'b01, 16'h0400, 8'h20, 8'h50, 8'h10, 8'hA5, 0);
    run(2'b01, 16'h0410, 8'hE0, 8'h50, 8'h30, 8'h3C, 0);
    run(2'b10, 16'h0500, 8'h10, 8'h3E, 8'h01, 8'hFF, 0);
    run(2'b10, 16'h0510, 8'hF8, 8'h12, 8'h10, 8'hFF, 0);
    run(2'b10, 16'h0520, 8'hC0, 8'hFF, 8'h50, 8'hAB, 0);
    run(2'b10, 16'h0530, 8'h01, 8'h7E, 8'h02, 8'h5A, 0);
    run(2'b00, 16'h0600, 8'hFE, 8'h60, 8'h04, 8'h00, 1);
    run(2'b01, 16'h0610, 8'h00, 8'h61, 8'hFF, 8'h99, 1);
    for (int t = 0; t < 20; t++)
      run(2'(t % 3), 16'(16'h0800 + t * 16), 8'(t * 37), 8'(t * 11 + 3), 8'(t * 53), 8'(t * 29 + 1), t[0]);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule